// File: doc/BRIEF.md
# Parallel RGB Display Output Formatter

This block sits between an upstream video timing generator and the pins of a parallel display bus. Each pixel clock it takes one 24-bit RGB pixel with its horizontal sync, vertical sync and data-enable strobes. It can reorder the three colour channels and then packs the result into one of several fixed 16-, 18- or 24-bit line layouts. The packed word and the three control strobes are driven onto the output pins.

A single control register sets up the formatting. For each control strobe it selects the polarity, a rising or falling launch edge, and whether the strobe is suppressed. It also holds a master enable. Every other address of the small 32-bit register bus returns a fixed identification word. The register bus runs on the pixel clock. The channel byte order on `pix_rgb` is red in bits 23:16, green in 15:8 and blue in 7:0.

Top module: `pix_bus_shaper`

## Requirements
- R1: A write at address 0 loads control bits 16:0. A read at address 0 returns them with bits 31:17 as zero, and the register resets to all zeros.
- R2: A read at any nonzero address returns 0x00647069. A write at a nonzero address leaves the control register unchanged.
- R3: Control bits 15:14 pick which incoming channels fill the first, second and third packed slots: 0 gives R,G,B; 1 gives B,G,R; 2 gives G,R,B; 3 gives B,R,G.
- R4: Control bits 13:11 select a 16-bit layout. Each layout keeps the upper 5, 6 and 5 bits of the three slots. Code 1 is {8 zeros, s1[7:3], s2[7:2], s3[7:3]}. Code 2 is {3 zeros, s1[7:3], 2 zeros, s2[7:2], 3 zeros, s3[7:3]}. Code 3 is {2 zeros, s1[7:3], 3 zeros, s2[7:2], 2 zeros, s3[7:3], 1 zero}.
- R5: Code 4 is {6 zeros, s1[7:2], s2[7:2], s3[7:2]}. Code 5 is {2 zeros, s1[7:2], 2 zeros, s2[7:2], 2 zeros, s3[7:2]}. Code 6 is {s1, s2, s3}.
- R6: Packing codes 0 and 7 drive all 24 data lines low.
- R7: Data lines, and each strobe in rising-launch mode, show the input sampled at a rising clock edge from just after that edge until the next one.
- R8: Bits 10, 9, 8 and 7 invert the pixel clock pin, hsync, vsync and output-enable respectively. While enabled, the pixel clock pin follows the clock, XOR its invert bit.
- R9: Bits 6, 5 and 4 move hsync, vsync and output-enable respectively to a falling-edge launch. The strobe then changes half a clock later than in rising mode.
- R10: Bits 3, 2 and 1 suppress hsync, vsync and output-enable respectively. A suppressed strobe sits at its inactive level, which is its invert bit.
- R11: Bit 16 set makes the output-enable strobe follow `de_in`. Bit 16 clear holds it active, which is high before inversion.
- R12: With bit 0 low, every output pin, including the pixel clock pin, is low. On the first rising edge after bit 0 goes from 0 to 1, all pipeline registers clear. Data then reads zero and each strobe reads its inactive level for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; also clocks the register bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational on address) |
| pix_rgb | input | 24 | Incoming pixel, R in 23:16, G in 15:8, B in 7:0 |
| hs_in | input | 1 | Horizontal sync from timing generator |
| vs_in | input | 1 | Vertical sync from timing generator |
| de_in | input | 1 | Data enable from timing generator |
| bus_data | output | 24 | Packed display data lines |
| bus_hs | output | 1 | Horizontal sync pin |
| bus_vs | output | 1 | Vertical sync pin |
| bus_oe | output | 1 | Output-enable pin |
| bus_pclk | output | 1 | Pixel clock pin |

## Verification
The packing table is driven with 0xA53CF0, whose three channels are all different. A wrong slot order or a swapped field therefore shows up as a different word. An all-ones pixel shows exactly which lines each layout leaves as padding. The pixels 0x5AC30F and 0x813E7C set low-order channel bits that the 5- and 6-bit layouts must drop, and so tell a truncated field from a misaligned one. The strobe tests drive hsync and vsync with opposite values under mixed invert, launch-edge and suppress settings, which separates each control bit from its neighbours.

// File: rtl/pixfmt_pkg.sv
package pixfmt_pkg;

  localparam int CH_W   = 8;
  localparam int PIX_W  = 3 * CH_W;
  localparam int CTRL_W = 17;
  localparam int N_STRB = 3;

  typedef enum logic [1:0] {
    ORD_RGB = 2'd0,
    ORD_BGR = 2'd1,
    ORD_GRB = 2'd2,
    ORD_BRG = 2'd3
  } ch_order_e;

  typedef enum logic [2:0] {
    PK_ZERO      = 3'd0,
    PK_565_LOW   = 3'd1,
    PK_565_BYTE  = 3'd2,
    PK_565_SHIFT = 3'd3,
    PK_666_LOW   = 3'd4,
    PK_666_BYTE  = 3'd5,
    PK_888       = 3'd6,
    PK_RSVD      = 3'd7
  } pack_e;

  // strobe index: 0 = output-enable, 1 = vsync, 2 = hsync
  typedef struct packed {
    logic              oe_mode;   // 16
    ch_order_e         order;     // 15:14
    pack_e             fmt;       // 13:11
    logic              clk_inv;   // 10
    logic [N_STRB-1:0] inv;       // 9:7
    logic [N_STRB-1:0] neg;       // 6:4
    logic [N_STRB-1:0] dis;       // 3:1
    logic              en;        // 0
  } ctrl_t;

  function automatic logic [PIX_W-1:0] chan_shuffle(input logic [PIX_W-1:0] px,
                                                     input ch_order_e ord);
    logic [CH_W-1:0] r, g, b;
    r = px[3*CH_W-1 -: CH_W];
    g = px[2*CH_W-1 -: CH_W];
    b = px[CH_W-1   -: CH_W];
    case (ord)
      ORD_BGR: return {b, g, r};
      ORD_GRB: return {g, r, b};
      ORD_BRG: return {b, r, g};
      default: return {r, g, b};
    endcase
  endfunction

  function automatic logic [PIX_W-1:0] pack_pixel(input logic [PIX_W-1:0] px,
                                                   input pack_e fmt);
    logic [CH_W-1:0] s1, s2, s3;
    s1 = px[3*CH_W-1 -: CH_W];
    s2 = px[2*CH_W-1 -: CH_W];
    s3 = px[CH_W-1   -: CH_W];
    case (fmt)
      PK_565_LOW:   return {8'b0, s1[7:3], s2[7:2], s3[7:3]};
      PK_565_BYTE:  return {3'b0, s1[7:3], 2'b0, s2[7:2], 3'b0, s3[7:3]};
      PK_565_SHIFT: return {2'b0, s1[7:3], 3'b0, s2[7:2], 2'b0, s3[7:3], 1'b0};
      PK_666_LOW:   return {6'b0, s1[7:2], s2[7:2], s3[7:2]};
      PK_666_BYTE:  return {2'b0, s1[7:2], 2'b0, s2[7:2], 2'b0, s3[7:2]};
      PK_888:       return {s1, s2, s3};
      default:      return '0;
    endcase
  endfunction

endpackage

// File: rtl/ctrl_regs.sv
module ctrl_regs
  import pixfmt_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] ID_VALUE = 32'h0064_7069
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl
);

  localparam int PAD_W = DATA_W - CTRL_W;

  logic ctrl_hit;
  assign ctrl_hit = (addr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ctrl <= '0;
    else if (we && ctrl_hit) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
  end

  assign rdata = ctrl_hit ? {{PAD_W{1'b0}}, ctrl} : DATA_W'(ID_VALUE);

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata[DATA_W-1:CTRL_W];

  p_ctrl_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(we && ctrl_hit) |-> (ctrl == ctrl_t'($past(wdata[CTRL_W-1:0]))));

  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(we && !ctrl_hit) |-> (ctrl == $past(ctrl)));

endmodule

// File: rtl/pix_pack_stage.sv
module pix_pack_stage
  import pixfmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  ch_order_e        order,
  input  pack_e            fmt,
  input  logic [PIX_W-1:0] pix_in,
  output logic [PIX_W-1:0] data_q
);

  logic [PIX_W-1:0] slots;
  logic [PIX_W-1:0] packed_w;

  assign slots    = chan_shuffle(pix_in, order);
  assign packed_w = pack_pixel(slots, fmt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   data_q <= '0;
    else if (clr) data_q <= '0;
    else          data_q <= packed_w;
  end

endmodule

// File: rtl/strobe_launch.sv
module strobe_launch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic dis,
  input  logic neg,
  input  logic inv,
  input  logic d,
  output logic q
);

  logic rise_q;
  logic fall_q;
  logic launched;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rise_q <= 1'b0;
    else if (clr) rise_q <= 1'b0;
    else          rise_q <= dis ? 1'b0 : d;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= rise_q;
  end

  assign launched = neg ? fall_q : rise_q;
  assign q        = en & (launched ^ inv);

  p_rise_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !neg && !$past(clr) && !$past(dis)) |-> (q == ($past(d) ^ inv)));

  p_dis_inactive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dis && $past(dis)) |-> (q == inv));

endmodule

// File: rtl/pix_bus_shaper.sv
module pix_bus_shaper
  import pixfmt_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] ID_VALUE = 32'h0064_7069
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [23:0]       pix_rgb,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic              de_in,
  output logic [23:0]       bus_data,
  output logic              bus_hs,
  output logic              bus_vs,
  output logic              bus_oe,
  output logic              bus_pclk
);

  ctrl_t ctrl;

  ctrl_regs #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .ID_VALUE(ID_VALUE)
  ) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (reg_we),
    .addr (reg_addr),
    .wdata(reg_wdata),
    .rdata(reg_rdata),
    .ctrl (ctrl)
  );

  // enable edge detection: a rising master enable clears the pipeline
  logic en_q;
  logic en_start;
  logic pipe_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= ctrl.en;
  end

  assign en_start = ctrl.en & ~en_q;
  assign pipe_clr = ~ctrl.en | en_start;

  logic [PIX_W-1:0] data_q;

  pix_pack_stage u_pack (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (pipe_clr),
    .order (ctrl.order),
    .fmt   (ctrl.fmt),
    .pix_in(pix_rgb),
    .data_q(data_q)
  );

  assign bus_data = ctrl.en ? data_q : '0;

  logic              oe_src;
  logic [N_STRB-1:0] strb_src;
  logic [N_STRB-1:0] strb_pin;

  assign oe_src   = ctrl.oe_mode ? de_in : 1'b1;
  assign strb_src = {hs_in, vs_in, oe_src};

  for (genvar i = 0; i < N_STRB; i++) begin : g_strobe
    strobe_launch u_launch (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (pipe_clr),
      .en   (ctrl.en),
      .dis  (ctrl.dis[i]),
      .neg  (ctrl.neg[i]),
      .inv  (ctrl.inv[i]),
      .d    (strb_src[i]),
      .q    (strb_pin[i])
    );
  end

  assign bus_oe   = strb_pin[0];
  assign bus_vs   = strb_pin[1];
  assign bus_hs   = strb_pin[2];
  assign bus_pclk = ctrl.en & (clk ^ ctrl.clk_inv);

  p_start_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.en && $past(ctrl.en) && !$past(en_q)) |-> (bus_data == '0));

  p_pass_888_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.en && $past(ctrl.en) && $past(en_q) && $past(ctrl.fmt) == PK_888 &&
     $past(ctrl.order) == ORD_RGB) |-> (bus_data == $past(pix_rgb)));

  p_pad_565_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.en && $past(ctrl.fmt) == PK_565_LOW) |-> (bus_data[23:16] == 8'h00));

  p_pad_666_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.en && $past(ctrl.fmt) == PK_666_BYTE) |->
    (bus_data[23:22] == 2'b00 && bus_data[15:14] == 2'b00 && bus_data[7:6] == 2'b00));

  p_zero_codes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl.fmt) == PK_ZERO || $past(ctrl.fmt) == PK_RSVD) |-> (bus_data == '0));

endmodule

// File: tb/pix_bus_shaper_bench.sv
module pix_bus_shaper_bench;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [31:0] ID_WORD = 32'h0064_7069;

  // control bit positions (R1, R3, R4, R8..R12)
  localparam logic [31:0] C_EN     = 32'h1;
  localparam logic [31:0] C_OE_DIS = 32'h1 << 1;
  localparam logic [31:0] C_VS_DIS = 32'h1 << 2;
  localparam logic [31:0] C_HS_DIS = 32'h1 << 3;
  localparam logic [31:0] C_OE_NEG = 32'h1 << 4;
  localparam logic [31:0] C_HS_NEG = 32'h1 << 6;
  localparam logic [31:0] C_OE_INV = 32'h1 << 7;
  localparam logic [31:0] C_VS_INV = 32'h1 << 8;
  localparam logic [31:0] C_HS_INV = 32'h1 << 9;
  localparam logic [31:0] C_CK_INV = 32'h1 << 10;
  localparam logic [31:0] C_OEMODE = 32'h1 << 16;

  // vector: {order[1:0], fmt[2:0], pixel[23:0]}
  localparam int NV = 16;
  localparam logic [28:0] VEC [NV] = '{
    {2'd0, 3'd6, 24'hA53CF0},
    {2'd1, 3'd6, 24'hA53CF0},
    {2'd2, 3'd6, 24'hA53CF0},
    {2'd3, 3'd6, 24'hA53CF0},
    {2'd0, 3'd1, 24'hA53CF0},
    {2'd0, 3'd2, 24'hA53CF0},
    {2'd0, 3'd3, 24'hA53CF0},
    {2'd0, 3'd4, 24'hA53CF0},
    {2'd0, 3'd5, 24'hA53CF0},
    {2'd0, 3'd0, 24'hFFFFFF},
    {2'd0, 3'd7, 24'hFFFFFF},
    {2'd0, 3'd3, 24'hFFFFFF},
    {2'd0, 3'd5, 24'hFFFFFF},
    {2'd1, 3'd2, 24'h5AC30F},
    {2'd3, 3'd4, 24'h813E7C},
    {2'd2, 3'd1, 24'h5AC30F}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic [23:0]       pix_rgb = '0;
  logic              hs_in = 1'b0, vs_in = 1'b0, de_in = 1'b0;
  logic [23:0]       bus_data;
  logic              bus_hs, bus_vs, bus_oe, bus_pclk;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pix_bus_shaper #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pix_bus_shaper (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pix_rgb(pix_rgb), .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in),
    .bus_data(bus_data), .bus_hs(bus_hs), .bus_vs(bus_vs), .bus_oe(bus_oe),
    .bus_pclk(bus_pclk)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = '0;
  endtask

  task automatic mid_high();
    @(posedge clk); #5;
  endtask

  task automatic mid_low();
    @(negedge clk); #5;
  endtask

  // independent model of slot order and line layout
  function automatic logic [23:0] model(input logic [1:0] ord, input logic [2:0] fmt,
                                        input logic [23:0] px);
    logic [23:0] r, g, b, a1, a2, a3;
    r = (px >> 16) & 24'hFF;
    g = (px >> 8) & 24'hFF;
    b = px & 24'hFF;
    case (ord)
      2'd0: begin a1 = r; a2 = g; a3 = b; end
      2'd1: begin a1 = b; a2 = g; a3 = r; end
      2'd2: begin a1 = g; a2 = r; a3 = b; end
      default: begin a1 = b; a2 = r; a3 = g; end
    endcase
    case (fmt)
      3'd1: return ((a1 >> 3) << 11) | ((a2 >> 2) << 5) | (a3 >> 3);
      3'd2: return ((a1 >> 3) << 16) | ((a2 >> 2) << 8) | (a3 >> 3);
      3'd3: return ((a1 >> 3) << 17) | ((a2 >> 2) << 8) | ((a3 >> 3) << 1);
      3'd4: return ((a1 >> 2) << 12) | ((a2 >> 2) << 6) | (a3 >> 2);
      3'd5: return ((a1 >> 2) << 16) | ((a2 >> 2) << 8) | (a3 >> 2);
      3'd6: return (a1 << 16) | (a2 << 8) | a3;
      default: return 24'h0;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    #5;
    // R12 / R1: reset state
    check("R12 reset data", {8'h0, bus_data}, 32'h0);
    check("R12 reset strobes", {28'h0, bus_hs, bus_vs, bus_oe, bus_pclk}, 32'h0);
    rst_n = 1'b1;
    rd(8'h00, rv); check("R1 reset ctrl", rv, 32'h0);

    // R2: identification reads, ignored writes
    rd(8'h04, rv); check("R2 id at 4", rv, ID_WORD);
    rd(8'h3C, rv); check("R2 id at 3C", rv, ID_WORD);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h00, rv); check("R2 write at 4 ignored", rv, 32'h0);

    // R1: readback and width
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, rv); check("R1 readback", rv, 32'h0001_FFFF);
    wr(8'h00, 32'h0);

    // main table: R3, R4, R5, R6, R7
    wr(8'h00, C_EN | C_OEMODE | (32'd6 << 11));
    repeat (3) @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  o;
      logic [2:0]  f;
      logic [23:0] p;
      {o, f, p} = VEC[i];
      wr(8'h00, C_EN | C_OEMODE | (32'(f) << 11) | (32'(o) << 14));
      pix_rgb = p;
      mid_high();
      check($sformatf("R3/R4/R5/R6/R7 vec %0d", i), {8'h0, bus_data}, {8'h0, model(o, f, p)});
    end

    // R7: strobes one cycle after a rising edge
    wr(8'h00, C_EN | C_OEMODE);
    @(negedge clk); hs_in = 1'b1; vs_in = 1'b0; de_in = 1'b1;
    mid_high();
    check("R7 strobes", {29'h0, bus_hs, bus_vs, bus_oe}, 32'b110 - 32'b010 + 32'b001);

    // R8: inversion of all strobes and the clock pin
    wr(8'h00, C_EN | C_OEMODE | C_HS_INV | C_VS_INV | C_OE_INV | C_CK_INV);
    @(negedge clk); hs_in = 1'b1; vs_in = 1'b1; de_in = 1'b0;
    mid_high();
    check("R8 inverted strobes", {29'h0, bus_hs, bus_vs, bus_oe}, 32'b001);
    check("R8 pclk inverted high phase", {31'h0, bus_pclk}, 32'h0);
    mid_low();
    check("R8 pclk inverted low phase", {31'h0, bus_pclk}, 32'h1);
    wr(8'h00, C_EN | C_OEMODE);
    mid_high();
    check("R8 pclk plain high phase", {31'h0, bus_pclk}, 32'h1);

    // R9: falling-edge launch on hsync only
    wr(8'h00, C_EN | C_OEMODE | C_HS_NEG);
    @(negedge clk); hs_in = 1'b0; vs_in = 1'b0;
    repeat (2) @(negedge clk);
    hs_in = 1'b1; vs_in = 1'b1;
    mid_high();
    check("R9 hs not yet launched", {31'h0, bus_hs}, 32'h0);
    check("R9 vs rising launch", {31'h0, bus_vs}, 32'h1);
    mid_low();
    check("R9 hs launched on falling edge", {31'h0, bus_hs}, 32'h1);

    // R10: suppression holds inactive level after inversion
    wr(8'h00, C_EN | C_OEMODE | C_HS_DIS | C_HS_INV | C_VS_DIS | C_OE_DIS | C_OE_INV | C_OE_NEG);
    @(negedge clk); hs_in = 1'b1; vs_in = 1'b1; de_in = 1'b1;
    repeat (2) mid_high();
    check("R10 suppressed strobes", {29'h0, bus_hs, bus_vs, bus_oe}, 32'b101);

    // R11: output-enable mode
    wr(8'h00, C_EN);
    @(negedge clk); de_in = 1'b0;
    mid_high();
    check("R11 mode 0 holds active", {31'h0, bus_oe}, 32'h1);
    wr(8'h00, C_EN | C_OEMODE);
    mid_high();
    check("R11 mode 1 follows de", {31'h0, bus_oe}, 32'h0);

    // R12: master enable off, then restart clearing
    pix_rgb = 24'hA53CF0; hs_in = 1'b1;
    wr(8'h00, C_HS_INV | C_CK_INV | (32'd6 << 11));
    repeat (2) mid_high();
    check("R12 off data", {8'h0, bus_data}, 32'h0);
    check("R12 off strobes high phase", {28'h0, bus_hs, bus_vs, bus_oe, bus_pclk}, 32'h0);
    mid_low();
    check("R12 off pclk low phase", {31'h0, bus_pclk}, 32'h0);
    wr(8'h00, C_EN | C_OEMODE | C_HS_INV | (32'd6 << 11));
    mid_high();
    check("R12 restart data cleared", {8'h0, bus_data}, 32'h0);
    check("R12 restart hs inactive", {31'h0, bus_hs}, 32'h1);
    mid_high();
    check("R12 after restart data", {8'h0, bus_data}, 32'h00A53CF0);
    check("R12 after restart hs", {31'h0, bus_hs}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule